// File: doc/BRIEF.md
# Masked Level Interrupt Collector

The block gathers up to sixteen level-sensitive interrupt lines from peripherals on a local bus and produces one combined interrupt request for the processor. Every clock it copies the line levels into a status register. A software-owned enable mask gates that register. Whenever a status bit and its enable bit are both set, the combined request is raised.

Software reaches the block through a small byte-addressed register window. Halfword offset 0 does not return a raw bitmap. It returns a vector code that identifies the lowest-numbered pending source. Software can then branch on that code directly, and a code of zero means nothing is pending. Halfword offset 2 holds the enable mask, which software can read and write.

Byte accesses are merged into the 16-bit registers. A 32-bit access is handled as two halfword accesses, one at the addressed halfword and one at the halfword two bytes higher. The window is combinational: read data is valid in the same cycle as the request, and a write takes effect at the next clock edge.

Top module: `lbic_top`

## Requirements
- R1: While reset is asserted, the status register and the mask are zero, `irq_out` is low, and reads of both registers return zero.
- R2: After each clock edge outside reset, status bit i equals the level that `irq_lvl[i]` had at that edge. It is set while the line is high and cleared once the line goes low.
- R3: `irq_out` is high exactly when at least one source has both its status bit and its mask bit set.
- R4: A halfword read at offset 0 returns (n+1)<<2, where n is the lowest-numbered source with both bits set. It returns 0 when no source qualifies.
- R5: A source whose mask bit is clear never raises `irq_out` and is never reported by the offset-0 code, whatever its level.
- R6: A halfword write at offset 2 (`acc_size`=1, data on `acc_wdata[15:0]`) replaces the mask at the next edge. A halfword read at offset 2 returns the mask.
- R7: A byte write (`acc_size`=0, data on `acc_wdata[7:0]`) to offset 2 replaces only mask bits 7:0, and a byte write to offset 3 replaces only mask bits 15:8. The other byte is kept.
- R8: A word access (`acc_size`=2) at a halfword offset h acts as two halfword accesses. The halfword at h uses `rd_data`/`acc_wdata` bits 15:0, and the halfword at h+2 uses bits 31:16.
- R9: Writes to offset 0 or 1, and writes to any offset above 3, leave the mask unchanged. Reads of offsets above 3 return zero.
- R10: A byte read returns the addressed byte of its halfword in `rd_data[7:0]`: even offsets give the low byte, odd offsets the high byte. The upper bits of `rd_data` are zero.
- R11: `rd_data` is zero whenever there is no read request (`acc_valid` low or `acc_write` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lvl | input | NUM_SRC | Peripheral interrupt levels, bit i is source i |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| acc_addr | input | ADDR_W | Byte offset within the window |
| acc_wdata | input | 32 | Write data, least significant lanes first |
| rd_data | output | 32 | Read data, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `acc_size` never takes the unused code 3 and that the interrupt levels and access fields are stable across each rising edge. The bench drives every input at the falling edge and draws sizes only from the three legal codes. The reset property assumes that reset is applied asynchronously and held across at least one rising edge. The bench keeps reset low for several cycles before releasing it at a falling edge, so each `$past` term refers only to cycles after reset.

// File: rtl/lbic_pkg.sv
package lbic_pkg;
    localparam int REG_W   = 16;
    localparam int BUS_W   = 32;
    localparam int SRC_OFF = 0;
    localparam int MSK_OFF = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] mask;
    } lbic_state_t;
endpackage

// File: rtl/lbic_prio_enc.sv
module lbic_prio_enc #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic [N-1:0] pend,
    output logic [W-1:0] code
);
    // Scan downwards so that the lowest pending index is written last.
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) code = W'((i + 1) << 2);
        end
    end
endmodule

// File: rtl/lbic_bus_port.sv
module lbic_bus_port
    import lbic_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [BUS_W-1:0]  acc_wdata,
    input  logic [REG_W-1:0]  src_code,
    input  logic [REG_W-1:0]  mask_q,
    output logic              mask_we,
    output logic [REG_W-1:0]  mask_wval,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int OFF_W = ADDR_W + 1;

    acc_size_e        size_e;
    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] off     [2];
    logic             act     [2];
    logic             hit_msk [2];
    logic [REG_W-1:0] rd_half [2];
    logic [REG_W-1:0] wr_half [2];

    assign size_e = acc_size_e'(acc_size);
    assign base   = {1'b0, acc_addr[ADDR_W-1:1], 1'b0};

    // One lane per halfword touched; the upper lane is live only for words.
    for (genvar h = 0; h < 2; h++) begin : g_lane
        assign off[h]     = base + OFF_W'(2 * h);
        assign act[h]     = acc_valid && (h == 0 || size_e == SZ_WORD);
        assign hit_msk[h] = act[h] && (off[h] == OFF_W'(MSK_OFF));

        always_comb begin
            if (off[h] == OFF_W'(SRC_OFF))      rd_half[h] = src_code;
            else if (off[h] == OFF_W'(MSK_OFF)) rd_half[h] = mask_q;
            else                                rd_half[h] = '0;
        end

        // Byte writes merge the new lane into the current halfword value.
        always_comb begin
            if (size_e == SZ_BYTE)
                wr_half[h] = acc_addr[0] ? {acc_wdata[7:0], rd_half[h][7:0]}
                                         : {rd_half[h][15:8], acc_wdata[7:0]};
            else
                wr_half[h] = acc_wdata[16*h +: 16];
        end
    end

    assign mask_we   = acc_write && (hit_msk[0] || hit_msk[1]);
    assign mask_wval = hit_msk[1] ? wr_half[1] : wr_half[0];

    always_comb begin
        rd_data = '0;
        if (acc_valid && !acc_write) begin
            case (size_e)
                SZ_BYTE: rd_data = {24'h0, acc_addr[0] ? rd_half[0][15:8] : rd_half[0][7:0]};
                SZ_HALF: rd_data = {16'h0, rd_half[0]};
                SZ_WORD: rd_data = {rd_half[1], rd_half[0]};
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/lbic_top.sv
module lbic_top
    import lbic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lvl,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [1:0]         acc_size,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [BUS_W-1:0]   acc_wdata,
    output logic [BUS_W-1:0]   rd_data,
    output logic               irq_out
);
    localparam logic [REG_W-1:0] LIVE = REG_W'((33'h1 << NUM_SRC) - 33'h1);

    lbic_state_t      state_d, state_q;
    logic [REG_W-1:0] pend;
    logic [REG_W-1:0] src_code;
    logic             mask_we;
    logic [REG_W-1:0] mask_wval;

    assign pend    = state_q.stat & state_q.mask;
    assign irq_out = |pend;

    lbic_prio_enc #(.N(REG_W), .W(REG_W)) u_enc (
        .pend (pend),
        .code (src_code)
    );

    lbic_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_size  (acc_size),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .src_code  (src_code),
        .mask_q    (state_q.mask),
        .mask_we   (mask_we),
        .mask_wval (mask_wval),
        .rd_data   (rd_data)
    );

    always_comb begin
        state_d      = state_q;
        state_d.stat = REG_W'(irq_lvl);
        if (mask_we) state_d.mask = mask_wval & LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/lbic_chk.sv
module lbic_chk
    import lbic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_lvl,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [1:0]         acc_size,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic [BUS_W-1:0]   acc_wdata,
    input logic [BUS_W-1:0]   rd_data,
    input logic               irq_out,
    input logic [REG_W-1:0]   stat,
    input logic [REG_W-1:0]   mask
);
    localparam logic [REG_W-1:0] LIVE = REG_W'((33'h1 << NUM_SRC) - 33'h1);

    logic rd_src_half, wr_msk_half, no_read;
    assign rd_src_half = acc_valid && !acc_write && acc_size == 2'd1 && acc_addr[ADDR_W-1:1] == '0;
    assign wr_msk_half = acc_valid && acc_write && acc_size == 2'd1
                         && acc_addr[ADDR_W-1:1] == (ADDR_W-1)'(1);
    assign no_read     = !acc_valid || acc_write;

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (!irq_out && stat == '0 && mask == '0);
        end
    end

    assert_status_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat == REG_W'($past(irq_lvl)));

    assert_irq_needs_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|irq_lvl));

    assert_code_vs_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_src_half |-> ((rd_data != '0) == irq_out));

    assert_code_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_src_half |-> (rd_data[1:0] == 2'b00 && rd_data[31:7] == '0));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_msk_half |=> mask == ($past(acc_wdata[15:0]) & LIVE));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=> $stable(mask));

    assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        no_read |-> rd_data == '0);
endmodule

bind lbic_top lbic_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lvl   (irq_lvl),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .rd_data   (rd_data),
    .irq_out   (irq_out),
    .stat      (state_q.stat),
    .mask      (state_q.mask)
);

// File: tb/test_lbic_top.sv
module test_lbic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lvl = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = 2'd1;
    logic [3:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    logic [15:0] m_stat = '0;
    logic [15:0] m_mask = '0;

    always #2 clk = ~clk;

    lbic_top i_lbic_top (
        .clk (clk), .rst_n (rst_n), .irq_lvl (irq_lvl),
        .acc_valid (acc_valid), .acc_write (acc_write), .acc_size (acc_size),
        .acc_addr (acc_addr), .acc_wdata (acc_wdata),
        .rd_data (rd_data), .irq_out (irq_out)
    );

    function automatic logic [15:0] m_half(int off);
        logic [15:0] p;
        p = m_stat & m_mask;
        if (off == 2) return m_mask;
        if (off != 0) return 16'h0;
        for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
        return 16'h0;
    endfunction

    function automatic logic [31:0] m_read(int sz, int addr);
        int a;
        logic [15:0] h;
        a = addr & ~1;
        h = m_half(a);
        if (sz == 0) return {24'h0, (addr & 1) ? h[15:8] : h[7:0]};
        if (sz == 1) return {16'h0, h};
        return {m_half(a + 2), h};
    endfunction

    task automatic m_write(int sz, int addr, logic [31:0] wd);
        int a;
        a = addr & ~1;
        if (sz == 0 && a == 2) begin
            if (addr & 1) m_mask[15:8] = wd[7:0];
            else          m_mask[7:0]  = wd[7:0];
        end
        if (sz == 1 && a == 2) m_mask = wd[15:0];
        if (sz == 2) begin
            if (a == 2) m_mask = wd[15:0];
            if (a == 0) m_mask = wd[31:16];
        end
    endtask

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(bit v, bit w, int sz, int addr, logic [31:0] wd,
                        logic [15:0] lvl, string tag);
        logic [31:0] exp;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_size = 2'(sz);
        acc_addr = 4'(addr); acc_wdata = wd; irq_lvl = lvl;
        #1;
        check(irq_out == |(m_stat & m_mask), {tag, "/R3 irq"}, 32'(irq_out),
              32'(|(m_stat & m_mask)));
        exp = (v && !w) ? m_read(sz, addr) : 32'h0;
        check(rd_data == exp, {tag, " rd"}, rd_data, exp);
        @(posedge clk);
        if (rst_n) begin
            m_stat = lvl;
            if (v && w) m_write(sz, addr, wd);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: state during reset
        step(1, 0, 1, 0, 0, 16'hFFFF, "R1 src");
        step(1, 0, 1, 2, 0, 16'hFFFF, "R1 mask");
        step(1, 1, 1, 2, 32'hFFFF, 16'hFFFF, "R1 write held");
        step(1, 0, 2, 0, 0, 16'hFFFF, "R1 word");
        @(negedge clk); rst_n = 1'b1;

        // R6: mask write and read back
        step(1, 1, 1, 2, 32'h0004, 16'h0005, "R6 write");
        step(1, 0, 1, 2, 0, 16'h0005, "R6 read");
        step(1, 0, 1, 0, 0, 16'h0005, "R4 single");
        // R4: lowest-numbered pending source wins
        step(1, 1, 1, 2, 32'hFFFF, 16'h8000, "R6 all");
        step(1, 0, 1, 0, 0, 16'h8001, "R4 top");
        step(1, 0, 1, 0, 0, 16'h0000, "R4 lowest");
        step(1, 0, 1, 0, 0, 16'h0000, "R2 drop");
        step(1, 0, 1, 0, 0, 16'h0000, "R4 none");
        // R5: masked sources stay silent
        step(1, 1, 1, 2, 32'h0100, 16'h00FF, "R5 mask");
        step(1, 0, 1, 0, 0, 16'h00FF, "R5 code");
        step(1, 0, 1, 0, 0, 16'h01FF, "R5 hidden");
        step(1, 0, 1, 0, 0, 16'h01FF, "R5 open");
        // R7: byte merges
        step(1, 1, 0, 2, 32'hEEEE_EE12, 16'h0, "R7 low");
        step(1, 1, 0, 3, 32'h0000_00AB, 16'h0, "R7 high");
        step(1, 0, 1, 2, 0, 16'h0, "R7 merged");
        // R10: byte reads
        step(1, 0, 0, 3, 0, 16'h0, "R10 odd");
        step(1, 0, 0, 2, 0, 16'h0, "R10 even");
        step(1, 0, 0, 0, 0, 16'h0010, "R10 src");
        step(1, 0, 0, 0, 0, 16'h0010, "R10 src code");
        // R8: word access
        step(1, 0, 2, 0, 0, 16'h0010, "R8 read");
        step(1, 1, 2, 0, 32'h5A5A_1234, 16'h0010, "R8 write hi");
        step(1, 0, 2, 0, 0, 16'h0010, "R8 readback");
        step(1, 1, 2, 2, 32'hFFFF_00F0, 16'h0010, "R8 write lo");
        step(1, 0, 2, 2, 0, 16'h0010, "R8 above");
        // R9: ignored writes and empty offsets
        step(1, 1, 1, 0, 32'hFFFF, 16'h0, "R9 src write");
        step(1, 1, 0, 1, 32'hFF, 16'h0, "R9 src byte");
        step(1, 1, 1, 6, 32'hFFFF, 16'h0, "R9 far write");
        step(1, 0, 1, 2, 0, 16'h0, "R9 mask kept");
        step(1, 0, 1, 6, 0, 16'h0, "R9 far read");
        step(1, 0, 2, 14, 0, 16'h0, "R9 far word");
        // R11: no read request
        step(0, 0, 1, 2, 0, 16'hFFFF, "R11 idle");
        step(1, 1, 1, 2, 32'h8421, 16'hFFFF, "R11 write");
        step(1, 0, 1, 0, 0, 16'hFFFF, "R4 after write");

        // R2/R3/R4: mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            step(($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0),
                 $urandom_range(0, 2), $urandom_range(0, 15), $urandom(),
                 16'($urandom()) & 16'($urandom()), "R2 mix");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule